// File: doc/BRIEF.md
# Per-Window Gamma and Palette Lookup Table

This block sits after the color converter of one display window. It holds one 256-entry table per color channel. For a true-color or YUV window, each 8-bit channel value addresses its own channel's table, which gives an RGB-to-RGB gamma curve. For a palette-indexed window, one 8-bit index addresses all three tables at once, and the three results form the palette color.

Pixels enter as a valid-qualified stream and leave exactly one cycle later. The input is never stalled, not even while the tables are being rewritten.

The host changes the table in one of three ways:
- It issues a range command: a start index, an entry count and an override flag. It then streams 16-bit-per-channel entries, and the block keeps the upper byte of each.
- It issues a command with a count of zero, which only changes the flag.
- It issues a clear, which rewrites every entry with its own index over 256 cycles.

The override flag is passed on to tell the downstream global table to step aside. When the flag is low, both lookups apply.

Top module: `gamma_palette_lut`

## Requirements
- R1: After `rst_n` rises, `busy_o` stays high for exactly 256 cycles while every entry of every channel is loaded with its own index. `override_o` and `pix_valid_o` read 0 after reset.
- R2: With `pix_palette_i`=0, output lane c is table c read at input lane c. Lane c sits at bits [8c+7:8c]: lane 0 is red, lane 1 green, lane 2 blue.
- R3: With `pix_palette_i`=1, every output lane c is table c read at input lane 0, and input lanes 1 and 2 are ignored.
- R4: `pix_valid_o` equals `pix_valid_i` of the previous cycle at all times, including while `busy_o` is high.
- R5: A command is accepted when `cmd_valid_i`=1, `clear_i`=0 and `busy_o`=0. Each later `wr_valid_i` beat writes the next entry, from `cmd_start_i` upward. Channel c takes bits [16c+15:16c+8] of `wr_data_i`, and its low byte is discarded. `busy_o` stays high until the last entry is written, and entries outside the range keep their values.
- R6: An accepted command with `cmd_len_i`=0 leaves `busy_o` low and the table unchanged.
- R7: When start plus count exceeds 256, writing stops after index 255. Further beats are ignored, and entry 0 is not touched.
- R8: `override_o` takes `cmd_override_i` on every accepted command and holds its value otherwise.
- R9: `clear_i` with `busy_o` low restores the identity table over 256 busy cycles. A command in the same cycle is dropped, and the flag keeps its value.
- R10: While `busy_o` is high, `clear_i` and `cmd_valid_i` are ignored. While no range update is running, `wr_valid_i` beats are ignored.
- R11: A pixel read in the same cycle as a host write to the same entry returns the newly written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pix_valid_i | input | 1 | Input pixel valid |
| pix_palette_i | input | 1 | 1 = palette index in lane 0, 0 = per-channel gamma |
| pix_data_i | input | 24 | Input lanes, lane 0 in the low byte |
| pix_valid_o | output | 1 | Output pixel valid, one cycle after input |
| pix_data_o | output | 24 | Looked-up lanes |
| clear_i | input | 1 | Restore identity table |
| cmd_valid_i | input | 1 | Range command strobe |
| cmd_start_i | input | 8 | First entry of the range |
| cmd_len_i | input | 9 | Entry count, 0 to 256 |
| cmd_override_i | input | 1 | New value of the override flag |
| wr_valid_i | input | 1 | Host entry beat valid |
| wr_data_i | input | 48 | Host entry, 16 bits per channel |
| busy_o | output | 1 | Fill or range update in progress |
| override_o | output | 1 | Skip the global lookup downstream |

## Verification
A pixel lookup and a host write can hit the same entry on the same clock edge. This is the one place where the pixel port and the host port meet. The bench provokes it by issuing a one-entry update and, on the cycle of its data beat, presenting a pixel whose lanes all address that entry. The output one cycle later must carry the new upper bytes, not the old table contents. A second overlap, pixels streaming while a clear or an update runs, is judged by requiring the valid output to follow the input without a gap.

// File: rtl/lut_pkg.sv
package lut_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_FILL = 2'd1,
      ST_UPD  = 2'd2
   } lut_state_e;

   // Width of an entry count that must be able to represent a full table
   function automatic int count_width(input int addr_w);
      return addr_w + 1;
   endfunction

endpackage

// File: rtl/lut_ram.sv
// One channel of the table: a write port for the host and the sequencer,
// a read port for the pixel stream, registered read data.
module lut_ram #(
   parameter int DATA_W    = 8,
   parameter int ADDR_W    = 8,
   parameter bit FWD_WRITE = 1'b1
) (
   input  logic              clk,
   input  logic              we_i,
   input  logic [ADDR_W-1:0] waddr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              re_i,
   input  logic [ADDR_W-1:0] raddr_i,
   output logic [DATA_W-1:0] rdata_o
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];
   logic [DATA_W-1:0] rdata_q;

   always_ff @(posedge clk) begin
      if (we_i) begin
         mem[waddr_i] <= wdata_i;
      end
   end

   generate
      if (FWD_WRITE) begin : g_fwd
         // The write wins on an address collision: the reader sees new data
         always_ff @(posedge clk) begin
            if (re_i) begin
               if (we_i && (waddr_i == raddr_i)) begin
                  rdata_q <= wdata_i;
               end else begin
                  rdata_q <= mem[raddr_i];
               end
            end
         end
      end else begin : g_rdfirst
         always_ff @(posedge clk) begin
            if (re_i) begin
               rdata_q <= mem[raddr_i];
            end
         end
      end
   endgenerate

   assign rdata_o = rdata_q;

endmodule

// File: rtl/lut_ctrl.sv
// Owns the write port: identity fill after reset or clear, and range
// updates fed by host beats. Also keeps the override flag.
module lut_ctrl
   import lut_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int HOST_W = 16,
   parameter int N_CH   = 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     clear_i,
   input  logic                     cmd_valid_i,
   input  logic [DATA_W-1:0]        cmd_start_i,
   input  logic [DATA_W:0]          cmd_len_i,
   input  logic                     cmd_override_i,
   input  logic                     wr_valid_i,
   input  logic [N_CH*HOST_W-1:0]   wr_data_i,
   output logic                     busy_o,
   output logic                     override_o,
   output logic                     we_o,
   output logic [DATA_W-1:0]        waddr_o,
   output logic [N_CH*DATA_W-1:0]   wdata_o
);
   localparam int ADDR_W = DATA_W;
   localparam int DEPTH  = 1 << ADDR_W;
   localparam int LEN_W  = count_width(ADDR_W);
   localparam int DROP_W = HOST_W - DATA_W;

   lut_state_e        state_q;
   logic [ADDR_W-1:0] ptr_q;
   logic [LEN_W-1:0]  remain_q;
   logic              ovr_q;

   logic [LEN_W-1:0]  room;
   logic [LEN_W-1:0]  clip_len;
   logic              cmd_take;
   logic              clr_take;

   assign room     = LEN_W'(DEPTH) - {1'b0, cmd_start_i};
   assign clip_len = (cmd_len_i > room) ? room : cmd_len_i;
   assign clr_take = (state_q == ST_IDLE) && clear_i;
   assign cmd_take = (state_q == ST_IDLE) && !clear_i && cmd_valid_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_FILL;
         ptr_q    <= '0;
         remain_q <= '0;
         ovr_q    <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (clr_take) begin
                  state_q <= ST_FILL;
                  ptr_q   <= '0;
               end else if (cmd_take) begin
                  ovr_q <= cmd_override_i;
                  if (cmd_len_i != '0) begin
                     state_q  <= ST_UPD;
                     ptr_q    <= cmd_start_i;
                     remain_q <= clip_len;
                  end
               end
            end
            ST_FILL: begin
               ptr_q <= ptr_q + 1'b1;
               if (ptr_q == ADDR_W'(DEPTH - 1)) begin
                  state_q <= ST_IDLE;
               end
            end
            ST_UPD: begin
               if (wr_valid_i) begin
                  ptr_q    <= ptr_q + 1'b1;
                  remain_q <= remain_q - 1'b1;
                  if (remain_q == LEN_W'(1)) begin
                     state_q <= ST_IDLE;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy_o     = (state_q != ST_IDLE);
   assign override_o = ovr_q;
   assign we_o       = (state_q == ST_FILL) || ((state_q == ST_UPD) && wr_valid_i);
   assign waddr_o    = ptr_q;

   logic [N_CH*DROP_W-1:0] unused_low_bytes;

   genvar c;
   generate
      for (c = 0; c < N_CH; c++) begin : g_lane
         logic [DATA_W-1:0] host_hi;
         assign host_hi = wr_data_i[c*HOST_W + DROP_W +: DATA_W];
         assign unused_low_bytes[c*DROP_W +: DROP_W] = wr_data_i[c*HOST_W +: DROP_W];
         assign wdata_o[c*DATA_W +: DATA_W] = (state_q == ST_FILL) ? ptr_q : host_hi;
      end
   endgenerate

endmodule

// File: rtl/lut_addr_sel.sv
// Chooses each channel's read address: its own lane in gamma mode,
// lane 0 for every channel in palette mode.
module lut_addr_sel #(
   parameter int DATA_W = 8,
   parameter int N_CH   = 3
) (
   input  logic                   palette_i,
   input  logic [N_CH*DATA_W-1:0] pix_i,
   output logic [N_CH*DATA_W-1:0] raddr_o
);
   genvar c;
   generate
      for (c = 0; c < N_CH; c++) begin : g_sel
         if (c == 0) begin : g_index_lane
            assign raddr_o[0 +: DATA_W] = pix_i[0 +: DATA_W];
         end else begin : g_other_lane
            assign raddr_o[c*DATA_W +: DATA_W] =
               palette_i ? pix_i[0 +: DATA_W] : pix_i[c*DATA_W +: DATA_W];
         end
      end
   endgenerate

endmodule

// File: rtl/gamma_palette_lut.sv
module gamma_palette_lut #(
   parameter int DATA_W    = 8,
   parameter int HOST_W    = 16,
   parameter int N_CH      = 3,
   parameter bit FWD_WRITE = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   pix_valid_i,
   input  logic                   pix_palette_i,
   input  logic [N_CH*DATA_W-1:0] pix_data_i,
   output logic                   pix_valid_o,
   output logic [N_CH*DATA_W-1:0] pix_data_o,
   input  logic                   clear_i,
   input  logic                   cmd_valid_i,
   input  logic [DATA_W-1:0]      cmd_start_i,
   input  logic [DATA_W:0]        cmd_len_i,
   input  logic                   cmd_override_i,
   input  logic                   wr_valid_i,
   input  logic [N_CH*HOST_W-1:0] wr_data_i,
   output logic                   busy_o,
   output logic                   override_o
);
   localparam int ADDR_W = DATA_W;
   localparam int PIX_W  = N_CH * DATA_W;

   generate
      if (N_CH < 1) begin : g_bad_ch
         $error("gamma_palette_lut: N_CH must be at least 1");
      end
      if (HOST_W < DATA_W) begin : g_bad_host
         $error("gamma_palette_lut: HOST_W must not be narrower than DATA_W");
      end
      if (DATA_W < 1 || DATA_W > 12) begin : g_bad_data
         $error("gamma_palette_lut: DATA_W out of range 1..12");
      end
   endgenerate

   logic              we;
   logic [ADDR_W-1:0] waddr;
   logic [PIX_W-1:0]  wdata;
   logic [PIX_W-1:0]  raddr;
   logic              vld_q;

   lut_ctrl #(
      .DATA_W (DATA_W),
      .HOST_W (HOST_W),
      .N_CH   (N_CH)
   ) u_ctrl (
      .clk            (clk),
      .rst_n          (rst_n),
      .clear_i        (clear_i),
      .cmd_valid_i    (cmd_valid_i),
      .cmd_start_i    (cmd_start_i),
      .cmd_len_i      (cmd_len_i),
      .cmd_override_i (cmd_override_i),
      .wr_valid_i     (wr_valid_i),
      .wr_data_i      (wr_data_i),
      .busy_o         (busy_o),
      .override_o     (override_o),
      .we_o           (we),
      .waddr_o        (waddr),
      .wdata_o        (wdata)
   );

   lut_addr_sel #(
      .DATA_W (DATA_W),
      .N_CH   (N_CH)
   ) u_sel (
      .palette_i (pix_palette_i),
      .pix_i     (pix_data_i),
      .raddr_o   (raddr)
   );

   genvar c;
   generate
      for (c = 0; c < N_CH; c++) begin : g_ch
         lut_ram #(
            .DATA_W    (DATA_W),
            .ADDR_W    (ADDR_W),
            .FWD_WRITE (FWD_WRITE)
         ) u_ram (
            .clk     (clk),
            .we_i    (we),
            .waddr_i (waddr),
            .wdata_i (wdata[c*DATA_W +: DATA_W]),
            .re_i    (pix_valid_i),
            .raddr_i (raddr[c*DATA_W +: DATA_W]),
            .rdata_o (pix_data_o[c*DATA_W +: DATA_W])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= 1'b0;
      end else begin
         vld_q <= pix_valid_i;
      end
   end

   assign pix_valid_o = vld_q;

endmodule

// File: rtl/gamma_palette_lut_chk.sv
module gamma_palette_lut_chk #(
   parameter int ADDR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              pix_valid_i,
   input logic              pix_valid_o,
   input logic              clear_i,
   input logic              cmd_valid_i,
   input logic [ADDR_W:0]   cmd_len_i,
   input logic              cmd_override_i,
   input logic              busy_o,
   input logic              override_o
);
   localparam int DEPTH = 1 << ADDR_W;

   logic              fill_mode;
   logic [ADDR_W+1:0] fill_cnt;
   logic              cmd_acc;

   assign cmd_acc = cmd_valid_i && !clear_i && !busy_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fill_mode <= 1'b1;
         fill_cnt  <= '0;
      end else if (clear_i && !busy_o) begin
         fill_mode <= 1'b1;
         fill_cnt  <= '0;
      end else if (fill_mode) begin
         if (fill_cnt == (ADDR_W+2)'(DEPTH)) begin
            fill_mode <= 1'b0;
         end else begin
            fill_cnt <= fill_cnt + 1'b1;
         end
      end
   end

   AST_VALID_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
      pix_valid_i |=> pix_valid_o); // R4

   AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !pix_valid_i |=> !pix_valid_o); // R4

   AST_FILL_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_mode && fill_cnt < (ADDR_W+2)'(DEPTH)) |-> busy_o); // R9

   AST_FILL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_mode && fill_cnt == (ADDR_W+2)'(DEPTH)) |-> !busy_o); // R1

   AST_ZERO_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_acc && cmd_len_i == '0) |=> !busy_o); // R6

   AST_OVR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_acc |=> (override_o == $past(cmd_override_i))); // R8

   AST_OVR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_acc |=> $stable(override_o)); // R10

   AST_UPD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_acc && cmd_len_i != '0) |=> busy_o); // R5

endmodule

bind gamma_palette_lut gamma_palette_lut_chk #(.ADDR_W(DATA_W)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .pix_valid_i    (pix_valid_i),
   .pix_valid_o    (pix_valid_o),
   .clear_i        (clear_i),
   .cmd_valid_i    (cmd_valid_i),
   .cmd_len_i      (cmd_len_i),
   .cmd_override_i (cmd_override_i),
   .busy_o         (busy_o),
   .override_o     (override_o)
);

// File: tb/gamma_palette_lut_test.sv
module gamma_palette_lut_test;
   localparam int CLK_PERIOD = 10;
   localparam int DW = 8;
   localparam int HW = 16;
   localparam int NC = 3;
   localparam int DEPTH = 256;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          pix_valid_i = 1'b0;
   logic          pix_palette_i = 1'b0;
   logic [NC*DW-1:0] pix_data_i = '0;
   logic          pix_valid_o;
   logic [NC*DW-1:0] pix_data_o;
   logic          clear_i = 1'b0;
   logic          cmd_valid_i = 1'b0;
   logic [DW-1:0] cmd_start_i = '0;
   logic [DW:0]   cmd_len_i = '0;
   logic          cmd_override_i = 1'b0;
   logic          wr_valid_i = 1'b0;
   logic [NC*HW-1:0] wr_data_i = '0;
   logic          busy_o;
   logic          override_o;

   gamma_palette_lut uut (
      .clk(clk), .rst_n(rst_n),
      .pix_valid_i(pix_valid_i), .pix_palette_i(pix_palette_i), .pix_data_i(pix_data_i),
      .pix_valid_o(pix_valid_o), .pix_data_o(pix_data_o),
      .clear_i(clear_i), .cmd_valid_i(cmd_valid_i), .cmd_start_i(cmd_start_i),
      .cmd_len_i(cmd_len_i), .cmd_override_i(cmd_override_i),
      .wr_valid_i(wr_valid_i), .wr_data_i(wr_data_i),
      .busy_o(busy_o), .override_o(override_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int n_chk = 0;
   int n_fail = 0;
   logic [7:0] mdl [NC][DEPTH];
   logic ovr_exp = 1'b0;

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cyc();
      @(posedge clk); #1;
   endtask

   task automatic model_identity();
      for (int c = 0; c < NC; c++)
         for (int i = 0; i < DEPTH; i++) mdl[c][i] = 8'(i);
   endtask

   function automatic logic [7:0] beat_val(input int c, input int i, input int seed);
      return 8'(seed * 7 + i * 13 + c * 71 + 1);
   endfunction

   task automatic pix_chk(input string req, input bit pal,
                          input logic [7:0] r, input logic [7:0] g, input logic [7:0] b);
      logic [7:0] lanes [NC];
      lanes[0] = r; lanes[1] = g; lanes[2] = b;
      @(negedge clk);
      pix_valid_i = 1'b1; pix_palette_i = pal; pix_data_i = {b, g, r};
      cyc();
      pix_valid_i = 1'b0;
      chk({req, " valid"}, int'(pix_valid_o), 1);
      for (int c = 0; c < NC; c++) begin
         logic [7:0] idx;
         idx = pal ? r : lanes[c];
         chk(req, int'(pix_data_o[c*DW +: DW]), int'(mdl[c][idx]));
      end
   endtask

   task automatic send_cmd(input int start, input int len, input bit ovr);
      @(negedge clk);
      cmd_valid_i = 1'b1; cmd_start_i = 8'(start); cmd_len_i = 9'(len); cmd_override_i = ovr;
      cyc();
      cmd_valid_i = 1'b0;
      ovr_exp = ovr;
   endtask

   task automatic drive_beat(input int i, input int seed);
      for (int c = 0; c < NC; c++)
         wr_data_i[c*HW +: HW] = {beat_val(c, i, seed), ~beat_val(c, i, seed)};
      wr_valid_i = 1'b1;
   endtask

   task automatic run_update(input string req, input int start, input int len,
                             input bit ovr, input int nbeats, input int seed);
      int clip;
      clip = (len > DEPTH - start) ? DEPTH - start : len;
      send_cmd(start, len, ovr);
      chk({req, " busy during update"}, int'(busy_o), (clip > 0) ? 1 : 0);
      for (int i = 0; i < nbeats; i++) begin
         @(negedge clk);
         drive_beat(i, seed);
         cyc();
         wr_valid_i = 1'b0;
         if (i < clip)
            for (int c = 0; c < NC; c++) mdl[c][start + i] = beat_val(c, i, seed);
      end
      chk({req, " busy after update"}, int'(busy_o), 0);
      chk({req, " override"}, int'(override_o), int'(ovr_exp));
   endtask

   task automatic wait_fill(input string req, input int already);
      int n;
      n = already;
      while (busy_o && n < 1000) begin
         cyc();
         n++;
      end
      chk({req, " fill length"}, n, DEPTH);
      model_identity();
   endtask

   // R1: reset state and initial identity fill
   task automatic test_reset();
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk("R1 busy at reset release", int'(busy_o), 1);
      chk("R1 override at reset", int'(override_o), 0);
      chk("R1 pixel valid at reset", int'(pix_valid_o), 0);
      wait_fill("R1", 0);
      pix_chk("R1 identity", 1'b0, 8'd0, 8'd128, 8'd255);
   endtask

   // R5, R2: range update and gamma lookup
   task automatic test_gamma();
      run_update("R5", 10, 4, 1'b0, 4, 3);
      pix_chk("R2 gamma updated entries", 1'b0, 8'd10, 8'd11, 8'd13);
      pix_chk("R5 neighbours untouched", 1'b0, 8'd9, 8'd14, 8'd200);
      pix_chk("R2 gamma mixed", 1'b0, 8'd12, 8'd77, 8'd10);
   endtask

   // R3: palette lookup uses lane 0 for every channel
   task automatic test_palette();
      pix_chk("R3 palette index 12", 1'b1, 8'd12, 8'd3, 8'd250);
      pix_chk("R3 palette index 40", 1'b1, 8'd40, 8'd11, 8'd10);
   endtask

   // R6, R8: zero-length command touches only the flag
   task automatic test_zero_len();
      send_cmd(50, 0, 1'b1);
      chk("R6 busy stays low", int'(busy_o), 0);
      chk("R8 override set", int'(override_o), 1);
      pix_chk("R6 table unchanged", 1'b0, 8'd50, 8'd11, 8'd12);
      send_cmd(0, 0, 1'b0);
      chk("R8 override cleared", int'(override_o), 0);
   endtask

   // R7: range clipped at the top entry
   task automatic test_clip();
      run_update("R7", 254, 5, 1'b1, 5, 9);
      pix_chk("R7 top entries written", 1'b0, 8'd254, 8'd255, 8'd0);
      pix_chk("R7 no wrap into low entries", 1'b0, 8'd0, 8'd1, 8'd2);
   endtask

   // R11: write and read of one entry in the same cycle
   task automatic test_collision();
      send_cmd(100, 1, 1'b0);
      @(negedge clk);
      drive_beat(0, 21);
      pix_valid_i = 1'b1; pix_palette_i = 1'b0; pix_data_i = {8'd100, 8'd100, 8'd100};
      cyc();
      wr_valid_i = 1'b0;
      pix_valid_i = 1'b0;
      for (int c = 0; c < NC; c++) mdl[c][100] = beat_val(c, 0, 21);
      for (int c = 0; c < NC; c++)
         chk("R11 collision returns new value", int'(pix_data_o[c*DW +: DW]), int'(mdl[c][100]));
      chk("R11 busy after single entry", int'(busy_o), 0);
   endtask

   // R9, R10, R4: clear with a competing command, inputs ignored while busy
   task automatic test_clear();
      int n;
      @(negedge clk);
      clear_i = 1'b1; cmd_valid_i = 1'b1; cmd_start_i = 8'd5;
      cmd_len_i = 9'd3; cmd_override_i = 1'b1;
      cyc();
      clear_i = 1'b0; cmd_valid_i = 1'b0;
      chk("R9 busy after clear", int'(busy_o), 1);
      chk("R9 command dropped, flag kept", int'(override_o), int'(ovr_exp));
      @(negedge clk);
      pix_valid_i = 1'b1; pix_data_i = 24'h0a0b0c;
      clear_i = 1'b1; cmd_valid_i = 1'b1; cmd_len_i = 9'd2; cmd_override_i = 1'b1;
      cyc();
      n = 1;
      pix_valid_i = 1'b0; clear_i = 1'b0; cmd_valid_i = 1'b0;
      chk("R4 valid passes while busy", int'(pix_valid_o), 1);
      chk("R10 flag unchanged while busy", int'(override_o), int'(ovr_exp));
      cyc();
      n++;
      chk("R4 valid drops after one cycle", int'(pix_valid_o), 0);
      wait_fill("R10 clear not restarted", n);
      chk("R10 override after fill", int'(override_o), int'(ovr_exp));
      pix_chk("R9 identity restored", 1'b0, 8'd10, 8'd100, 8'd254);
      pix_chk("R9 identity palette", 1'b1, 8'd255, 8'd0, 8'd0);
   endtask

   // R10: stray beats while idle
   task automatic test_stray_beats();
      @(negedge clk);
      drive_beat(0, 33);
      cyc();
      @(negedge clk);
      drive_beat(1, 33);
      cyc();
      wr_valid_i = 1'b0;
      chk("R10 busy stays low on stray beats", int'(busy_o), 0);
      pix_chk("R10 stray beats ignored", 1'b0, 8'd0, 8'd1, 8'd255);
      pix_chk("R10 stray beats ignored high", 1'b0, 8'd101, 8'd102, 8'd2);
   endtask

   initial begin
      model_identity();
      test_reset();
      test_gamma();
      test_palette();
      test_zero_len();
      test_clip();
      test_collision();
      test_clear();
      test_stray_beats();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule